// File: doc/BRIEF.md
# Stepped Digital Attenuator with Soft Mute

This block holds the running attenuation code for a group of output channels and walks each one toward its programmed target one code at a time. It only moves on step boundaries, and there is one step for every eight sample-rate ticks. A counter that all channels share produces that boundary. Code 255 is unity gain, and each lower code adds one step of attenuation. The step is half a decibel in fine mode and one decibel in wide mode. Below a mode-dependent floor the channel is silent, and its code is forced to 0.

A soft mute request makes the channel step down from wherever it is. When it reaches the floor, the next step drops the code to 0. Releasing the mute brings the channel back in at the lowest audible code, and it then climbs step by step to the stored target. The mode bit is read only at step boundaries. A channel that sits between the fine and wide floors when wide mode takes effect is muted at that step. A downstream multiplier takes the code and a per-channel mute indicator. The indicator also covers channels whose converter is disabled.

Top module: `att_ramp_top`

## Requirements
- R1: After reset every channel code is 255 and every mute indicator is 0.
- R2: Channel codes change only on the clock edge that accepts every eighth `fs_tick_i` pulse counted from reset. They hold through all other cycles and ticks.
- R3: On each step a channel whose code is at or above the floor and differs from an audible target moves exactly one code toward the target. It stops when the two are equal.
- R4: In fine mode (`wide_i`=0) the floor is 129. A target of 128 or below counts as mute. A downward step from 129 goes straight to code 0.
- R5: In wide mode (`wide_i`=1) the floor is 155. A target of 154 or below counts as mute. A downward step from 155 goes straight to code 0.
- R6: While `mute_i` of a channel is 1, its code steps down one code per step from its current value, and then drops to 0 as in R4 and R5.
- R7: On a step where a channel's code is 0 and its effective goal is audible, the code becomes the floor of the active mode (129 or 155). From there it ramps up one code per step.
- R8: `wide_i` is sampled only at step boundaries. A non-zero code below the active floor at a step becomes 0 on that step.
- R9: `mute_o` of a channel is 1 exactly when its code is 0 or its `dac_off_i` bit is 1. `dac_off_i` never alters the code.
- R10: Each channel follows only its own target, mute and disable bits, so channels with different settings evolve independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fs_tick_i | input | 1 | One-cycle pulse per sample period |
| wide_i | input | 1 | Step/range mode: 0 fine, 1 wide |
| target_i | input | NUM_CH*CODE_W | Programmed target code per channel, channel 0 in the low byte |
| mute_i | input | NUM_CH | Soft mute request per channel |
| dac_off_i | input | NUM_CH | Converter disable per channel |
| level_o | output | NUM_CH*CODE_W | Current attenuation code per channel |
| mute_o | output | NUM_CH | Silence indicator per channel |

## Verification
A code update is due one clock edge after the eighth tick is presented. That edge is the one that samples the tick, with a single register in the path. `mute_o` follows the code or `dac_off_i` within the same cycle. The bench drives every input on a falling edge. It advances its own tick count and expected codes at the moment it raises the tick, and compares all channels on the next falling edge. It also compares on every idle cycle between ticks to confirm the codes hold.

// File: rtl/att_pkg.sv
package att_pkg;
  typedef enum logic {
    MODE_FINE = 1'b0,
    MODE_WIDE = 1'b1
  } att_mode_e;
endpackage

// File: rtl/att_step_gen.sv
module att_step_gen #(
  parameter int STEP_TICKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fs_tick_i,
  output logic step_o
);
  localparam int CNT_W = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign step_o = fs_tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (step_o)    cnt_q <= '0;
    else if (fs_tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // R2: after a step the counter restarts, so steps are never back to back
  p_step_spacing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o);

  p_cnt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fs_tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/att_chan.sv
module att_chan
  import att_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int FINE_FLOOR = 129,
  parameter int WIDE_FLOOR = 155
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  att_mode_e         mode_i,
  input  logic [CODE_W-1:0] target_i,
  input  logic              mute_i,
  input  logic              dac_off_i,
  output logic [CODE_W-1:0] level_o,
  output logic              mute_o
);
  localparam logic [CODE_W-1:0] FINE_C = CODE_W'(FINE_FLOOR);
  localparam logic [CODE_W-1:0] WIDE_C = CODE_W'(WIDE_FLOOR);

  logic [CODE_W-1:0] floor_c, goal_c, level_q, level_d;

  assign floor_c = (mode_i == MODE_WIDE) ? WIDE_C : FINE_C;
  // targets under the floor are silence
  assign goal_c  = (mute_i || (target_i < floor_c)) ? '0 : target_i;

  always_comb begin
    level_d = level_q;
    if (level_q == '0) begin
      if (goal_c != '0) level_d = floor_c;
    end else if (level_q < floor_c) begin
      level_d = '0;
    end else if (goal_c > level_q) begin
      level_d = level_q + 1'b1;
    end else if (goal_c < level_q) begin
      level_d = (level_q == floor_c) ? '0 : level_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     level_q <= '1;
    else if (step_i) level_q <= level_d;
  end

  assign level_o = level_q;
  assign mute_o  = (level_q == '0) || dac_off_i;

  p_hold_off_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(level_q));

  p_one_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((level_q != $past(level_q)) && ($past(level_q) != '0) && (level_q != '0))
      |-> ((level_q == $past(level_q) + 1'b1) || (level_q == $past(level_q) - 1'b1)));

  p_reentry_floor_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(level_q) == '0) && (level_q != '0)) |-> ((level_q == FINE_C) || (level_q == WIDE_C)));

  p_no_sub_floor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q == '0) || (level_q >= FINE_C));

  p_dac_off_mutes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_off_i |-> mute_o);
endmodule

// File: rtl/att_ramp_top.sv
module att_ramp_top
  import att_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int CODE_W     = 8,
  parameter int STEP_TICKS = 8,
  parameter int FINE_FLOOR = 129,
  parameter int WIDE_FLOOR = 155
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     fs_tick_i,
  input  logic                     wide_i,
  input  logic [NUM_CH*CODE_W-1:0] target_i,
  input  logic [NUM_CH-1:0]        mute_i,
  input  logic [NUM_CH-1:0]        dac_off_i,
  output logic [NUM_CH*CODE_W-1:0] level_o,
  output logic [NUM_CH-1:0]        mute_o
);
  logic      step;
  att_mode_e mode;

  assign mode = att_mode_e'(wide_i);

  att_step_gen #(.STEP_TICKS(STEP_TICKS)) u_step (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fs_tick_i(fs_tick_i),
    .step_o   (step)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    att_chan #(
      .CODE_W    (CODE_W),
      .FINE_FLOOR(FINE_FLOOR),
      .WIDE_FLOOR(WIDE_FLOOR)
    ) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .step_i   (step),
      .mode_i   (mode),
      .target_i (target_i[c*CODE_W +: CODE_W]),
      .mute_i   (mute_i[c]),
      .dac_off_i(dac_off_i[c]),
      .level_o  (level_o[c*CODE_W +: CODE_W]),
      .mute_o   (mute_o[c])
    );
  end
endmodule

// File: tb/sim_att_ramp_top.sv
module sim_att_ramp_top;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fs_tick = 1'b0;
  logic wide = 1'b0;
  logic [7:0] tgt [NCH];
  logic [NCH-1:0] mut = '0;
  logic [NCH-1:0] doff = '0;
  logic [NCH*8-1:0] target_bus, level_bus;
  logic [NCH-1:0] mute_bus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R1";

  int m_lvl [NCH];
  int m_cnt = 0;

  always #5 clk = ~clk;

  always_comb
    for (int c = 0; c < NCH; c++) target_bus[c*8 +: 8] = tgt[c];

  att_ramp_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fs_tick_i(fs_tick), .wide_i(wide),
    .target_i(target_bus), .mute_i(mut), .dac_off_i(doff),
    .level_o(level_bus), .mute_o(mute_bus)
  );

  function automatic int next_lvl(int lvl, int t, bit m, bit w);
    int fl = w ? 155 : 129;
    int g = (m || t < fl) ? 0 : t;
    if (lvl == 0) return (g != 0) ? fl : 0;
    if (lvl < fl) return 0;
    if (g > lvl) return lvl + 1;
    if (g < lvl) return (lvl == fl) ? 0 : lvl - 1;
    return lvl;
  endfunction

  task automatic compare();
    for (int c = 0; c < NCH; c++) begin
      int got = int'(level_bus[c*8 +: 8]);
      bit em = (m_lvl[c] == 0) || doff[c];
      checks++;
      if (got != m_lvl[c]) begin
        errors++;
        $display("FAIL %s ch%0d level actual=%0d expected=%0d", tag, c, got, m_lvl[c]);
      end
      checks++;
      if (mute_bus[c] != em) begin
        errors++;
        $display("FAIL %s ch%0d mute actual=%0b expected=%0b", tag, c, mute_bus[c], em);
      end
    end
  endtask

  task automatic do_tick(int idle);
    for (int i = 0; i < idle; i++) begin
      @(negedge clk);
      compare();
    end
    fs_tick = 1'b1;
    if (m_cnt == 7) begin
      m_cnt = 0;
      for (int c = 0; c < NCH; c++) m_lvl[c] = next_lvl(m_lvl[c], int'(tgt[c]), mut[c], wide);
    end else m_cnt++;
    @(negedge clk);
    fs_tick = 1'b0;
    compare();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) do_tick(i % 3);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NCH; c++) begin tgt[c] = 8'd255; m_lvl[c] = 255; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    tag = "R1"; compare();

    // R2: seven ticks hold, eighth moves
    tag = "R2"; tgt[0] = 8'd250;
    ticks(7);
    ticks(1);
    tag = "R3"; tgt[5] = 8'd200;
    ticks(80);
    // R4: fine mode, target below floor ends in 0 after 129
    tag = "R4"; tgt[1] = 8'd100;
    ticks(1030);
    // R6/R5: mute in wide mode
    tag = "R6"; wide = 1'b1; mut[2] = 1'b1;
    ticks(400);
    tag = "R5"; tgt[6] = 8'd154;
    ticks(420);
    // R7: unmute re-enters at 155
    tag = "R7"; mut[2] = 1'b0;
    ticks(120);
    // R8: fine level 140, then wide drops it, then fine re-enters at 129
    tag = "R8"; wide = 1'b0; tgt[3] = 8'd140;
    ticks(940);
    wide = 1'b1;
    ticks(16);
    wide = 1'b0;
    ticks(120);
    // R9: disable forces indicator only
    tag = "R9"; doff[4] = 1'b1; tgt[4] = 8'd240;
    ticks(140);
    doff[4] = 1'b0;
    ticks(8);
    // R10: random mixes
    tag = "R10";
    for (int it = 0; it < 300; it++) begin
      int ch = $urandom_range(0, NCH - 1);
      case ($urandom_range(0, 4))
        0: tgt[ch] = 8'($urandom_range(0, 255));
        1: tgt[ch] = 8'($urandom_range(120, 170));
        2: mut[ch] = ~mut[ch];
        3: doff[ch] = ~doff[ch];
        default: wide = ~wide;
      endcase
      for (int k = 0; k < int'($urandom_range(1, 24)); k++) do_tick($urandom_range(0, 2));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule